// File: doc/BRIEF.md
# Four-Bit Eight-Function Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for unsigned 4-bit operands. A 3-bit operation code chooses one of eight functions: addition with carry, subtraction in either operand order with a borrow input and output, doubling, halving, truncating multiplication, bitwise exclusive-OR and an unsigned less-than test. It returns a 4-bit result and three status flags: zero, overflow and carry/borrow.

Each function has its own datapath. The top level runs all of them in parallel and selects one set of result and flags with a multiplexer driven by the operation code. No storage element lies anywhere in the path, so the outputs follow the inputs within the same cycle. A single input bit acts as carry-in for addition and as borrow-in for both subtractions. The other five functions ignore it.

Top module: `alu4`

## Requirements
- R1: With op_sel = 001, res_f is the low 4 bits of op_a + op_b + op_x, and flag_c is the carry out of bit 3. For example, 0100 + 0011 with op_x = 0 gives res_f = 0111 with flag_z = 0, flag_v = 0 and flag_c = 0.
- R2: With op_sel = 010, res_f is (op_b − op_a − op_x) mod 16, and flag_c is 1 exactly when op_b < op_a + op_x.
- R3: With op_sel = 011, res_f is (op_a − op_b − op_x) mod 16, and flag_c is 1 exactly when op_a < op_b + op_x.
- R4: With op_sel = 100, res_f is (2·op_a) mod 16, and flag_v equals op_a bit 3, meaning the doubled value does not fit in 4 bits.
- R5: With op_sel = 101, res_f is op_a shifted right by one with a 0 entering bit 3, and flag_v equals op_a bit 0, the bit shifted out.
- R6: With op_sel = 110, res_f is the low 4 bits of op_a·op_b, and flag_v is 1 exactly when the full product exceeds 15.
- R7: With op_sel = 111, res_f is op_a XOR op_b, bit by bit.
- R8: With op_sel = 000, res_f is 0001 when op_a < op_b as unsigned values, and 0000 otherwise.
- R9: For every operation, flag_z is 1 exactly when res_f is 0000.
- R10: flag_c is 0 for every code other than 001, 010 and 011. flag_v is 0 for codes 000, 001, 010, 011 and 111.
- R11: For codes 000, 100, 101, 110 and 111, op_x has no effect on res_f, flag_z, flag_v or flag_c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 4 | First operand, unsigned |
| op_b | input | 4 | Second operand, unsigned |
| op_x | input | 1 | Carry-in for addition, borrow-in for subtraction |
| op_sel | input | 3 | Operation code |
| res_f | output | 4 | Result of the selected operation |
| flag_z | output | 1 | Set when res_f is zero |
| flag_v | output | 1 | Overflow or shifted-out bit for double, halve and multiply |
| flag_c | output | 1 | Carry out for addition, borrow out for subtraction |

## Verification
Uniformly random operation codes, operands and carry bits exercise every function across its value range. They separate the two subtraction orders wherever op_a ≠ op_b, and they reveal swapped flag roles between datapaths.

Directed vectors add the boundaries that random draws may miss:
- the sample addition;
- all-ones operands with a carry-in, which wrap the adder;
- zero minus one with a borrow, which gives the deepest borrow;
- multiply products of exactly 15 and 16, which sit on the overflow edge;
- equal operands for the less-than test;
- halving of odd and even values.

Each non-arithmetic code is applied twice, once with op_x at 0 and once at 1. Any difference between the two responses exposes a carry input that leaks into a function that must ignore it.

// File: rtl/alu4_pkg.sv
// alu4_pkg: shared operation codes for the four-bit ALU.
// Assumes a fixed 3-bit select; the codes are the external contract.
package alu4_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        OP_LT   = 3'b000,
        OP_ADD  = 3'b001,
        OP_BSA  = 3'b010,
        OP_ASB  = 3'b011,
        OP_DBL  = 3'b100,
        OP_HLV  = 3'b101,
        OP_MUL  = 3'b110,
        OP_XOR  = 3'b111
    } alu_op_e;

endpackage

// File: rtl/alu4_ripple.sv
// alu4_ripple: W-bit ripple-carry adder, or subtractor when SUB = 1.
// In subtract mode it computes p - q - cin by adding ~q with carry-in ~cin.
// flag_out is carry out (add) or borrow out (subtract). Purely combinational.
module alu4_ripple #(
    parameter int W   = 4,
    parameter bit SUB = 1'b0
) (
    input  logic [W-1:0] p,
    input  logic [W-1:0] q,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         flag_out
);

    logic [W:0]   cy;
    logic [W-1:0] qq;

    // Pick operand and carry polarity for the selected variant.
    generate
        if (SUB) begin : g_sub
            assign qq       = ~q;
            assign cy[0]    = ~cin;
            assign flag_out = ~cy[W];
        end else begin : g_add
            assign qq       = q;
            assign cy[0]    = cin;
            assign flag_out = cy[W];
        end
    endgenerate

    // One full-adder cell per bit; the carry ripples upward.
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]  = p[i] ^ qq[i] ^ cy[i];
            assign cy[i+1] = (p[i] & qq[i]) | (cy[i] & (p[i] ^ qq[i]));
        end
    endgenerate

endmodule

// File: rtl/alu4_mult.sv
// alu4_mult: unsigned W x W array multiplier built from shifted partial products.
// Produces the full 2W-bit product; the caller truncates it and flags overflow.
module alu4_mult #(
    parameter int W = 4
) (
    input  logic [W-1:0]   p,
    input  logic [W-1:0]   q,
    output logic [2*W-1:0] prod
);

    localparam int PW = 2 * W;

    logic [PW-1:0] acc [0:W];

    assign acc[0] = '0;

    // Each row adds p shifted by i when multiplier bit i is set.
    generate
        for (genvar i = 0; i < W; i++) begin : g_row
            logic [PW-1:0] pp;
            assign pp       = q[i] ? ({{W{1'b0}}, p} << i) : '0;
            assign acc[i+1] = acc[i] + pp;
        end
    endgenerate

    assign prod = acc[W];

endmodule

// File: rtl/alu4_bitops.sv
// alu4_bitops: shift, logic and compare datapaths of the ALU.
// Doubling flags the bit shifted out at the top and halving flags the bit
// shifted out at the bottom. The compare treats the operands as unsigned.
module alu4_bitops #(
    parameter int W = 4
) (
    input  logic [W-1:0] p,
    input  logic [W-1:0] q,
    output logic [W-1:0] dbl_f,
    output logic         dbl_v,
    output logic [W-1:0] hlv_f,
    output logic         hlv_v,
    output logic [W-1:0] xor_f,
    output logic [W-1:0] lt_f
);

    // Doubling: shift left one place; the lost MSB is the overflow.
    assign dbl_f = {p[W-2:0], 1'b0};
    assign dbl_v = p[W-1];

    // Halving: shift right one place; the lost LSB is reported.
    assign hlv_f = {1'b0, p[W-1:1]};
    assign hlv_v = p[0];

    // Bitwise exclusive-OR of the operands.
    assign xor_f = p ^ q;

    // Unsigned less-than, returned as 0...01 or 0...00.
    assign lt_f  = {{(W-1){1'b0}}, (p < q)};

endmodule

// File: rtl/alu4.sv
// alu4: combinational eight-function ALU, top level.
// All datapaths run in parallel and the operation code selects one result
// and its flags. Z is derived from the selected result. No clock or state.
module alu4
    import alu4_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    input  logic             op_x,
    input  logic [SEL_W-1:0] op_sel,
    output logic [W-1:0]     res_f,
    output logic             flag_z,
    output logic             flag_v,
    output logic             flag_c
);

    localparam int PW = 2 * W;

    logic [W-1:0]  add_f, bsa_f, asb_f;
    logic          add_c, bsa_c, asb_c;
    logic [PW-1:0] mul_p;
    logic [W-1:0]  dbl_f, hlv_f, xor_f, lt_f;
    logic          dbl_v, hlv_v;
    alu_op_e       op;

    // Adder: a + b + x.
    alu4_ripple #(.W(W), .SUB(1'b0)) u_add (
        .p(op_a), .q(op_b), .cin(op_x), .sum(add_f), .flag_out(add_c)
    );

    // Subtractor: b - a - x.
    alu4_ripple #(.W(W), .SUB(1'b1)) u_bsa (
        .p(op_b), .q(op_a), .cin(op_x), .sum(bsa_f), .flag_out(bsa_c)
    );

    // Subtractor: a - b - x.
    alu4_ripple #(.W(W), .SUB(1'b1)) u_asb (
        .p(op_a), .q(op_b), .cin(op_x), .sum(asb_f), .flag_out(asb_c)
    );

    // Full-width product for the truncating multiply.
    alu4_mult #(.W(W)) u_mul (
        .p(op_a), .q(op_b), .prod(mul_p)
    );

    // Shift, XOR and compare datapaths.
    alu4_bitops #(.W(W)) u_bit (
        .p(op_a), .q(op_b),
        .dbl_f(dbl_f), .dbl_v(dbl_v),
        .hlv_f(hlv_f), .hlv_v(hlv_v),
        .xor_f(xor_f), .lt_f(lt_f)
    );

    assign op = alu_op_e'(op_sel);

    // Route the selected datapath's result and flags to the outputs.
    always_comb begin
        res_f  = '0;
        flag_v = 1'b0;
        flag_c = 1'b0;
        unique case (op)
            OP_ADD: begin res_f = add_f;       flag_c = add_c;        end
            OP_BSA: begin res_f = bsa_f;       flag_c = bsa_c;        end
            OP_ASB: begin res_f = asb_f;       flag_c = asb_c;        end
            OP_DBL: begin res_f = dbl_f;       flag_v = dbl_v;        end
            OP_HLV: begin res_f = hlv_f;       flag_v = hlv_v;        end
            OP_MUL: begin res_f = mul_p[W-1:0]; flag_v = |mul_p[PW-1:W]; end
            OP_XOR: begin res_f = xor_f;                              end
            OP_LT:  begin res_f = lt_f;                               end
            default: ;
        endcase
    end

    // Zero flag from the selected result.
    assign flag_z = (res_f == '0);

endmodule

// File: rtl/alu4_checker.sv
// alu4_checker: port-level properties of alu4, attached by bind.
// The block has no clock, so the checks are immediate assertions
// evaluated whenever the inputs or outputs change.
module alu4_checker
    import alu4_pkg::*;
#(
    parameter int W = 4
) (
    input logic [W-1:0]     op_a,
    input logic [W-1:0]     op_b,
    input logic             op_x,
    input logic [SEL_W-1:0] op_sel,
    input logic [W-1:0]     res_f,
    input logic             flag_z,
    input logic             flag_v,
    input logic             flag_c
);

    logic [W:0] add_ref;

    // Extended sum for the addition check.
    assign add_ref = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, op_x};

    // Port relations per requirement.
    always_comb begin
        p_add_sum_r1: assert (op_sel != OP_ADD || {flag_c, res_f} == add_ref)
            else $error("add result mismatch");
        p_double_shift_r4: assert (op_sel != OP_DBL || (res_f[0] == 1'b0 && flag_v == op_a[W-1]))
            else $error("double mismatch");
        p_halve_shift_r5: assert (op_sel != OP_HLV || (res_f[W-1] == 1'b0 && flag_v == op_a[0]))
            else $error("halve mismatch");
        p_xor_inverse_r7: assert (op_sel != OP_XOR || (res_f ^ op_a) == op_b)
            else $error("xor mismatch");
        p_lt_range_r8: assert (op_sel != OP_LT || res_f[W-1:1] == '0)
            else $error("compare out of range");
        p_zero_flag_r9: assert (flag_z == (res_f == '0))
            else $error("zero flag mismatch");
        p_no_carry_r10: assert (op_sel == OP_ADD || op_sel == OP_BSA || op_sel == OP_ASB || !flag_c)
            else $error("carry outside arithmetic");
        p_no_overflow_r10: assert (op_sel == OP_DBL || op_sel == OP_HLV || op_sel == OP_MUL || !flag_v)
            else $error("overflow outside shift or multiply");
    end

endmodule

bind alu4 alu4_checker #(.W(W)) u_chk (
    .op_a(op_a), .op_b(op_b), .op_x(op_x), .op_sel(op_sel),
    .res_f(res_f), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
);

// File: tb/tb_alu4.sv
// tb_alu4: random plus directed self-checking bench for alu4.
`timescale 1ns/1ps
module tb_alu4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_a = '0, op_b = '0;
    logic       op_x = 1'b0;
    logic [2:0] op_sel = '0;
    logic [3:0] res_f;
    logic       flag_z, flag_v, flag_c;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    alu4 dut (
        .op_a(op_a), .op_b(op_b), .op_x(op_x), .op_sel(op_sel),
        .res_f(res_f), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    // 200 MHz clock paces the stimulus.
    always #2.5 clk = ~clk;

    // Reference model: returns {f, z, v, c}.
    function automatic logic [6:0] model(input logic [2:0] s, input logic x,
                                         input logic [3:0] a, input logic [3:0] b);
        int t;
        logic [3:0] f;
        logic v, c;
        v = 0; c = 0; f = 0;
        case (s)
            3'b001: begin t = a + b + x; f = t[3:0]; c = (t > 15); end
            3'b010: begin t = int'(b) - int'(a) - int'(x); f = t[3:0]; c = (t < 0); end
            3'b011: begin t = int'(a) - int'(b) - int'(x); f = t[3:0]; c = (t < 0); end
            3'b100: begin t = 2 * a; f = t[3:0]; v = (t > 15); end
            3'b101: begin f = a / 2; v = a[0]; end
            3'b110: begin t = a * b; f = t[3:0]; v = (t > 15); end
            3'b111: f = a ^ b;
            default: f = (a < b) ? 4'd1 : 4'd0;
        endcase
        return {f, (f == 0), v, c};
    endfunction

    function automatic string op_req(input logic [2:0] s);
        case (s)
            3'b001: return "R1";
            3'b010: return "R2";
            3'b011: return "R3";
            3'b100: return "R4";
            3'b101: return "R5";
            3'b110: return "R6";
            3'b111: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d (sel=%b x=%b a=%0d b=%0d)",
                     req, what, act, exp, op_sel, op_x, op_a, op_b);
        end
    endtask

    // Drive at the falling edge, sample 1 ns later.
    task automatic apply(input logic [11:0] w);
        logic [6:0] e;
        @(negedge clk);
        {op_sel, op_x, op_a, op_b} = w;
        #1;
        e = model(op_sel, op_x, op_a, op_b);
        chk(op_req(op_sel), "F", res_f, e[6:3]);
        chk("R9", "Z", flag_z, e[2]);
        chk((op_sel inside {3'b100, 3'b101, 3'b110}) ? op_req(op_sel) : "R10", "V", flag_v, e[1]);
        chk((op_sel inside {3'b001, 3'b010, 3'b011}) ? op_req(op_sel) : "R10", "C", flag_c, e[0]);
    endtask

    // R11: same vector with x = 0 and x = 1 must match.
    task automatic x_ignored(input logic [2:0] s, input logic [3:0] a, input logic [3:0] b);
        logic [6:0] r0, r1;
        apply({s, 1'b0, a, b});
        r0 = {res_f, flag_z, flag_v, flag_c};
        apply({s, 1'b1, a, b});
        r1 = {res_f, flag_z, flag_v, flag_c};
        chk("R11", "x-insensitive", r1, r0);
    endtask

    // Watchdog.
    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // Idle state: code 000 with zero operands gives F = 0, Z = 1 (R8, R9).
        chk("R8", "idle F", res_f, 0);
        chk("R9", "idle Z", flag_z, 1);

        // Directed corners.
        apply(12'h243);                              // R1 sample: 4+3 -> 7
        chk("R1", "sample F", res_f, 7);
        apply({3'b001, 1'b1, 4'hF, 4'hF});           // R1 wrap with carry
        apply({3'b010, 1'b1, 4'h1, 4'h0});           // R2 deepest borrow
        apply({3'b010, 1'b1, 4'h3, 4'h4});           // R2 zero result no borrow
        apply({3'b011, 1'b1, 4'h0, 4'h0});           // R3 borrow from zero
        apply({3'b011, 1'b0, 4'h9, 4'h2});           // R3 plain
        apply({3'b100, 1'b0, 4'h8, 4'h0});           // R4 overflow, F = 0
        apply({3'b100, 1'b0, 4'h7, 4'h0});           // R4 no overflow
        apply({3'b101, 1'b0, 4'h7, 4'h0});           // R5 odd
        apply({3'b101, 1'b0, 4'h6, 4'h0});           // R5 even
        apply({3'b110, 1'b0, 4'h5, 4'h3});           // R6 product 15
        apply({3'b110, 1'b0, 4'h4, 4'h4});           // R6 product 16
        apply({3'b111, 1'b0, 4'hA, 4'hA});           // R7 zero
        apply({3'b000, 1'b0, 4'h6, 4'h6});           // R8 equal
        apply({3'b000, 1'b0, 4'h5, 4'h6});           // R8 less

        // R11: x has no effect on the five non-arithmetic codes.
        for (int k = 0; k < 40; k++) begin
            logic [2:0] s;
            case (k % 5)
                0: s = 3'b000;
                1: s = 3'b100;
                2: s = 3'b101;
                3: s = 3'b110;
                default: s = 3'b111;
            endcase
            x_ignored(s, 4'($urandom), 4'($urandom));
        end

        // Random vectors over all codes.
        for (int n = 0; n < 2000; n++) begin
            apply(12'($urandom));
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule